// File: doc/BRIEF.md
# Five-Phase Multicycle Teaching Processor

This block is a small processor that makes the inner workings of instruction execution visible one clock at a time. It holds two 8-bit general registers (AX and BX), a program counter, an instruction register, a memory-address register and a memory-data register. Every instruction walks through the same five phases: fetch, decode with register read, ALU, memory access and write-back. It does this even when an instruction has nothing to do in a phase. A phase output shows which step is running, and debug outputs show the registers, so a learner or a bench can follow each instruction cycle by cycle.

The instruction and data arrays are held inside the block. A program is written into the instruction array through a valid/ready load port while reset is held. The load port applies back-pressure at all other times: `prog_ready` is high only while `rst` is high, so a beat completes only on a rising edge where `prog_valid` and `prog_ready` are both high. A source that sees `prog_ready` low must hold its beat until reset is asserted again. Once reset is released, the core runs from address 0 until it fetches a halt instruction. It then stops and raises `halted` until the next reset.

An instruction is 16 bits wide. Bits [15:12] hold the opcode, bit [8] selects the destination or source register (0 = AX, 1 = BX), bits [7:0] hold the operand, and bits [11:9] are ignored. The opcodes are 0x1 (load immediate), 0x2 (load from memory), 0x3 (store), 0x4 (add) and 0xF (halt).

Top module: `cpu5_core`

## Requirements
- R1: A synchronous active-high reset clears AX, BX, the program counter, carry, zero, `halted` and every data-memory word, and sets the phase to 0.
- R2: While the core is not halted, the phase output steps 0, 1, 2, 3, 4, 0 one step per clock for every instruction, including phases the instruction does not use (0 fetch, 1 decode, 2 ALU, 3 memory, 4 write-back).
- R3: The program counter advances by one only on the clock edge that leaves phase 0, and holds in every other phase.
- R4: Opcode 0x1 loads operand bits [7:0] into the register picked by bit 8.
- R5: Opcode 0x2 loads the selected register from data memory at the address (operand modulo data depth). The register changes only on the edge that leaves phase 4.
- R6: Opcode 0x3 writes the selected register into data memory at (operand modulo data depth) on the edge that leaves phase 3, and leaves the register unchanged.
- R7: Opcode 0x4 writes (selected + other) modulo 256 into the selected register and leaves the other register unchanged. Carry takes the bit-8 overflow and zero is set when the sum is 0. Only this opcode changes the flags.
- R8: Fetching opcode 0xF raises `halted` on that edge. The phase then stays at 0, and the program counter, registers and flags stay frozen until reset.
- R9: The load port accepts a beat only when `prog_valid` and `prog_ready` are both high, and `prog_ready` is high only while reset is asserted. A beat offered while the core runs changes nothing.
- R10: Any other opcode runs all five phases and changes no register, flag or memory word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_valid | input | 1 | Program load beat is valid |
| prog_ready | output | 1 | Program load port can accept a beat (reset held) |
| prog_addr | input | IAW | Instruction array address for the beat |
| prog_data | input | IW | Instruction word for the beat |
| phase | output | 3 | Current phase, 0 to 4 |
| halted | output | 1 | Core has stopped on a halt instruction |
| carry | output | 1 | Carry out of the last add |
| zero | output | 1 | Last add produced zero |
| dbg_ax | output | DW | AX contents |
| dbg_bx | output | DW | BX contents |
| dbg_pc | output | IAW | Program counter |

## Verification
The assertions watch the timing skeleton on every cycle. They check that the phase always steps in order and stays in range, that the program counter moves only when leaving fetch, that registers and flags change only at write-back, and that a halt stays halted on phase 0 with a frozen counter. Only the bench's programs can show that the values are right: the operand or memory word a load delivers, a store that lands at the right wrapped address and is later read back, the carry and zero values of an add, the clearing of memory by reset, and a load beat refused while the core runs.

// File: rtl/cpu5_pkg.sv
package cpu5_pkg;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_ALU    = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4
  } phase_t;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LDI  = 4'h1;
  localparam logic [OPC_W-1:0] OP_LDM  = 4'h2;
  localparam logic [OPC_W-1:0] OP_STM  = 4'h3;
  localparam logic [OPC_W-1:0] OP_ADD  = 4'h4;
  localparam logic [OPC_W-1:0] OP_HALT = 4'hF;

endpackage

// File: rtl/cpu5_sequencer.sv
module cpu5_sequencer
  import cpu5_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   halt_seen,
  output phase_t phase,
  output logic   halted
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_FETCH;
      halted <= 1'b0;
    end else if (!halted) begin
      case (phase)
        PH_FETCH: begin
          if (halt_seen) halted <= 1'b1;
          else           phase  <= PH_DECODE;
        end
        PH_DECODE: phase <= PH_ALU;
        PH_ALU:    phase <= PH_MEM;
        PH_MEM:    phase <= PH_WB;
        PH_WB:     phase <= PH_FETCH;
        default:   phase <= PH_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/cpu5_imem.sv
module cpu5_imem #(
  parameter int IW    = 16,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cpu5_dmem.sv
module cpu5_dmem #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/cpu5_datapath.sv
module cpu5_datapath
  import cpu5_pkg::*;
#(
  parameter int DW  = 8,
  parameter int IAW = 5,
  parameter int DAW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_t           phase,
  input  logic             fetch_go,
  input  logic [OPC_W-1:0] in_op,
  input  logic             in_sel,
  input  logic [DW-1:0]    in_opnd,
  input  logic [DW-1:0]    dmem_rdata,
  output logic             dmem_we,
  output logic [DAW-1:0]   dmem_addr,
  output logic [DW-1:0]    dmem_wdata,
  output logic [IAW-1:0]   pc,
  output logic [DW-1:0]    ax,
  output logic [DW-1:0]    bx,
  output logic             carry,
  output logic             zero
);

  logic [OPC_W-1:0] ir_op;
  logic             ir_sel;
  logic [DW-1:0]    ir_opnd;
  logic [DW-1:0]    opa, opb;
  logic [DW:0]      alu_q;
  logic [DAW-1:0]   mar;
  logic [DW-1:0]    mdr;
  logic             wr_en;
  logic [DW-1:0]    wr_val;

  // write-back source selection
  always_comb begin
    wr_en  = 1'b0;
    wr_val = '0;
    if (phase == PH_WB) begin
      case (ir_op)
        OP_LDI, OP_ADD: begin wr_en = 1'b1; wr_val = alu_q[DW-1:0]; end
        OP_LDM:         begin wr_en = 1'b1; wr_val = mdr; end
        default:        ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      ir_op   <= '0;
      ir_sel  <= 1'b0;
      ir_opnd <= '0;
      opa     <= '0;
      opb     <= '0;
      alu_q   <= '0;
      mar     <= '0;
      mdr     <= '0;
      ax      <= '0;
      bx      <= '0;
      carry   <= 1'b0;
      zero    <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH: if (fetch_go) begin
          ir_op   <= in_op;
          ir_sel  <= in_sel;
          ir_opnd <= in_opnd;
          pc      <= pc + 1'b1;
        end
        PH_DECODE: begin
          opa <= ir_sel ? bx : ax;
          opb <= ir_sel ? ax : bx;
        end
        PH_ALU: begin
          case (ir_op)
            OP_ADD:         alu_q <= {1'b0, opa} + {1'b0, opb};
            OP_LDI:         alu_q <= {1'b0, ir_opnd};
            OP_LDM, OP_STM: mar   <= ir_opnd[DAW-1:0];
            default:        ;
          endcase
        end
        PH_MEM: if (ir_op == OP_LDM) mdr <= dmem_rdata;
        PH_WB: begin
          if (wr_en) begin
            if (ir_sel) bx <= wr_val;
            else        ax <= wr_val;
          end
          if (ir_op == OP_ADD) begin
            carry <= alu_q[DW];
            zero  <= (alu_q[DW-1:0] == '0);
          end
        end
        default: ;
      endcase
    end
  end

  assign dmem_we    = (phase == PH_MEM) && (ir_op == OP_STM);
  assign dmem_addr  = mar;
  assign dmem_wdata = opa;

endmodule

// File: rtl/cpu5_core.sv
module cpu5_core
  import cpu5_pkg::*;
#(
  parameter int DW     = 8,
  parameter int IDEPTH = 32,
  parameter int DDEPTH = 16,
  parameter int IAW    = $clog2(IDEPTH),
  parameter int IW     = DW + 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           prog_valid,
  output logic           prog_ready,
  input  logic [IAW-1:0] prog_addr,
  input  logic [IW-1:0]  prog_data,
  output logic [2:0]     phase,
  output logic           halted,
  output logic           carry,
  output logic           zero,
  output logic [DW-1:0]  dbg_ax,
  output logic [DW-1:0]  dbg_bx,
  output logic [IAW-1:0] dbg_pc
);

  localparam int DAW = $clog2(DDEPTH);

  phase_t            ph;
  logic [IW-1:0]     instr;
  logic [OPC_W-1:0]  f_op;
  logic              f_sel;
  logic [DW-1:0]     f_opnd;
  logic              halt_seen;
  logic              fetch_go;
  logic              dm_we;
  logic [DAW-1:0]    dm_addr;
  logic [DW-1:0]     dm_wdata, dm_rdata;
  logic [IAW-1:0]    pc;
  logic              unused_pad;

  assign prog_ready = rst;

  assign f_op       = instr[IW-1 -: OPC_W];
  assign f_sel      = instr[DW];
  assign f_opnd     = instr[DW-1:0];
  assign unused_pad = ^instr[IW-OPC_W-1:DW+1];
  assign halt_seen  = (f_op == OP_HALT);
  assign fetch_go   = (ph == PH_FETCH) && !halted && !halt_seen;

  cpu5_imem #(.IW(IW), .DEPTH(IDEPTH), .AW(IAW)) u_imem (
    .clk   (clk),
    .we    (prog_valid && prog_ready),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc),
    .rdata (instr)
  );

  cpu5_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .halt_seen (halt_seen),
    .phase     (ph),
    .halted    (halted)
  );

  cpu5_datapath #(.DW(DW), .IAW(IAW), .DAW(DAW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .phase      (ph),
    .fetch_go   (fetch_go),
    .in_op      (f_op),
    .in_sel     (f_sel),
    .in_opnd    (f_opnd),
    .dmem_rdata (dm_rdata),
    .dmem_we    (dm_we),
    .dmem_addr  (dm_addr),
    .dmem_wdata (dm_wdata),
    .pc         (pc),
    .ax         (dbg_ax),
    .bx         (dbg_bx),
    .carry      (carry),
    .zero       (zero)
  );

  cpu5_dmem #(.DW(DW), .DEPTH(DDEPTH), .AW(DAW)) u_dmem (
    .clk   (clk),
    .rst   (rst),
    .we    (dm_we),
    .addr  (dm_addr),
    .wdata (dm_wdata),
    .rdata (dm_rdata)
  );

  assign phase  = ph;
  assign dbg_pc = pc;

endmodule

// File: rtl/cpu5_core_checker.sv
module cpu5_core_checker #(
  parameter int DW  = 8,
  parameter int IAW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     phase,
  input logic           halted,
  input logic           carry,
  input logic           zero,
  input logic [DW-1:0]  dbg_ax,
  input logic [DW-1:0]  dbg_bx,
  input logic [IAW-1:0] dbg_pc
);

  // R2: phase never leaves the range 0..4
  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    phase <= 3'd4);

  // R2: every non-fetch phase steps to the next one, wrapping after 4
  p_phase_next_r2: assert property (@(posedge clk) disable iff (rst)
    (phase != 3'd0) |=>
      (phase == (($past(phase) == 3'd4) ? 3'd0 : $past(phase) + 3'd1)));

  // R2/R8: a running fetch moves on to decode unless it stops on halt
  p_leave_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && !halted) |=> (phase == 3'd1 || halted));

  // R3: program counter holds outside fetch
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phase != 3'd0) |=> $stable(dbg_pc));

  // R5: registers change only on the edge leaving write-back
  p_regs_wb_only_r5: assert property (@(posedge clk) disable iff (rst)
    (phase != 3'd4) |=> ($stable(dbg_ax) && $stable(dbg_bx)));

  // R7: flags change only on the edge leaving write-back
  p_flags_wb_only_r7: assert property (@(posedge clk) disable iff (rst)
    (phase != 3'd4) |=> ($stable(carry) && $stable(zero)));

  // R8: halt is sticky, parks on phase 0 and freezes the counter
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && phase == 3'd0 && $stable(dbg_pc)));

endmodule

bind cpu5_core cpu5_core_checker #(.DW(DW), .IAW(IAW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .phase  (phase),
  .halted (halted),
  .carry  (carry),
  .zero   (zero),
  .dbg_ax (dbg_ax),
  .dbg_bx (dbg_bx),
  .dbg_pc (dbg_pc)
);

// File: tb/cpu5_core_tb.sv
`timescale 1ns/1ps
module cpu5_core_tb;

  localparam int DW = 8, IDEPTH = 32, DDEPTH = 16, IAW = 5, IW = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           prog_valid = 1'b0;
  logic           prog_ready;
  logic [IAW-1:0] prog_addr = '0;
  logic [IW-1:0]  prog_data = '0;
  logic [2:0]     phase;
  logic           halted, carry, zero;
  logic [DW-1:0]  dbg_ax, dbg_bx;
  logic [IAW-1:0] dbg_pc;

  always #2.5 clk = ~clk;

  cpu5_core u_dut (
    .clk(clk), .rst(rst), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data), .phase(phase),
    .halted(halted), .carry(carry), .zero(zero),
    .dbg_ax(dbg_ax), .dbg_bx(dbg_bx), .dbg_pc(dbg_pc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [IW-1:0] prog [IDEPTH];
  int            plen;
  logic [DW-1:0] mem_m [DDEPTH];
  logic [DW-1:0] ax_m, bx_m;
  logic          c_m, z_m;
  int            pc_m;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] enc(logic [3:0] op, logic sel, logic [7:0] v);
    return {op, 3'b000, sel, v};
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'h1: return "R4";
      4'h2: return "R5";
      4'h3: return "R6";
      4'h4: return "R7";
      default: return "R10";
    endcase
  endfunction

  // reference step computed from the requirement text
  task automatic model_step(logic [IW-1:0] ins);
    logic [3:0] op;
    logic       sel;
    logic [7:0] v, d, o;
    logic [8:0] s;
    op  = ins[15:12];
    sel = ins[8];
    v   = ins[7:0];
    d   = sel ? bx_m : ax_m;
    o   = sel ? ax_m : bx_m;
    case (op)
      4'h1: d = v;
      4'h2: d = mem_m[v % DDEPTH];
      4'h3: mem_m[v % DDEPTH] = d;
      4'h4: begin
        s   = {1'b0, d} + {1'b0, o};
        d   = s[7:0];
        c_m = s[8];
        z_m = (s[7:0] == 8'h00);
      end
      default: ;
    endcase
    if (sel) bx_m = d; else ax_m = d;
    pc_m++;
  endtask

  task automatic load_and_reset();
    rst = 1'b1;
    prog_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < plen; i++) begin
      prog_valid = 1'b1;
      prog_addr  = IAW'(i);
      prog_data  = prog[i];
      chk("R9", "prog_ready during reset", int'(prog_ready), 1);
      @(negedge clk);
    end
    prog_valid = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "ax", int'(dbg_ax), 0);
    chk("R1", "bx", int'(dbg_bx), 0);
    chk("R1", "pc", int'(dbg_pc), 0);
    chk("R1", "phase", int'(phase), 0);
    chk("R1", "halted", int'(halted), 0);
    chk("R1", "flags", int'({carry, zero}), 0);
    for (int i = 0; i < DDEPTH; i++) mem_m[i] = '0;
    ax_m = '0; bx_m = '0; c_m = 1'b0; z_m = 1'b0; pc_m = 0;
    rst = 1'b0;
  endtask

  task automatic run_prog(bit poke);
    logic [IW-1:0] ins;
    for (int n = 0; n < IDEPTH; n++) begin
      ins = prog[pc_m];
      if (ins[15:12] == 4'hF) begin
        @(posedge clk); @(negedge clk);
        chk("R8", "halted after halt fetch", int'(halted), 1);
        chk("R8", "phase parked", int'(phase), 0);
        chk("R8", "pc on halt", int'(dbg_pc), pc_m % IDEPTH);
        repeat (3) @(negedge clk);
        chk("R8", "still halted", int'(halted), 1);
        chk("R8", "pc frozen", int'(dbg_pc), pc_m % IDEPTH);
        chk("R8", "ax frozen", int'(dbg_ax), int'(ax_m));
        chk("R8", "bx frozen", int'(dbg_bx), int'(bx_m));
        return;
      end
      if (poke && n == 0) begin
        // R9: offer a beat while running; it must be refused
        prog_valid = 1'b1;
        prog_addr  = IAW'(pc_m + 1);
        prog_data  = enc(4'hF, 1'b0, 8'h00);
        chk("R9", "prog_ready while running", int'(prog_ready), 0);
      end
      for (int p = 1; p <= 5; p++) begin
        @(posedge clk); @(negedge clk);
        prog_valid = 1'b0;
        chk("R2", "phase step", int'(phase), p % 5);
        if (p == 1) chk("R3", "pc after fetch", int'(dbg_pc), (pc_m + 1) % IDEPTH);
        if (p == 4) begin
          chk("R5", "ax before write-back", int'(dbg_ax), int'(ax_m));
          chk("R5", "bx before write-back", int'(dbg_bx), int'(bx_m));
        end
      end
      model_step(ins);
      chk(tag_of(ins[15:12]), "ax", int'(dbg_ax), int'(ax_m));
      chk(tag_of(ins[15:12]), "bx", int'(dbg_bx), int'(bx_m));
      chk(tag_of(ins[15:12]), "carry", int'(carry), int'(c_m));
      chk(tag_of(ins[15:12]), "zero", int'(zero), int'(z_m));
    end
    chk("R8", "program reached halt", 0, 1);
  endtask

  function automatic logic [3:0] pick_op();
    case ($urandom % 8)
      0: return 4'h1;
      1, 2: return 4'h2;
      3, 4: return 4'h3;
      5, 6: return 4'h4;
      default: return ($urandom % 2) ? 4'h7 : 4'h0;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd5150));

    // directed: overflow, store/load back, cleared memory, unused opcode
    prog[0] = enc(4'h1, 1'b0, 8'hFF);
    prog[1] = enc(4'h1, 1'b1, 8'h01);
    prog[2] = enc(4'h4, 1'b0, 8'h00);   // R7: FF+01 -> 00, carry 1, zero 1
    prog[3] = enc(4'h3, 1'b1, 8'h13);   // R6: address wraps to 3
    prog[4] = enc(4'h2, 1'b0, 8'h03);   // R5: reads back 01
    prog[5] = enc(4'h2, 1'b1, 8'h09);   // R1: untouched word reads 00
    prog[6] = enc(4'h4, 1'b1, 8'h00);   // R7: 00+01 -> 01
    prog[7] = enc(4'h9, 1'b0, 8'h55);   // R10: no effect
    prog[8] = enc(4'hF, 1'b0, 8'h00);
    plen = 9;
    load_and_reset();
    run_prog(1'b1);
    chk("R6", "stored value read back into ax", int'(dbg_ax), 8'h01);
    chk("R7", "bx after second add", int'(dbg_bx), 8'h01);
    chk("R7", "carry cleared by add", int'(carry), 0);

    // constrained random programs
    for (int r = 0; r < 6; r++) begin
      plen = 12 + ($urandom % 18);
      for (int i = 0; i < plen - 1; i++)
        prog[i] = enc(pick_op(), 1'($urandom % 2), 8'($urandom));
      prog[plen-1] = enc(4'hF, 1'b0, 8'($urandom));
      load_and_reset();
      run_prog(r[0]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule